// File: doc/BRIEF.md
# DLL Reset And Lock Sequencer

This block brings an on-chip delay-locked loop out of reset in a fixed order of steps, then waits for the loop to report lock. A single start strobe begins the sequence. The block then drives two configuration words and a clock power-save control. These outputs sit at the bit positions that the delay line decodes. When the sequence ends, the block raises a one-cycle completion flag, or a one-cycle timeout flag if lock never arrived. The delay line itself is outside the block. It receives the configuration words and returns a lock status bit.

Each step takes one clock cycle. First the block disables clock power-save, so the delay line's clock keeps running. Next it asserts reset and then power-down. It programs a 3-bit band code picked from the bus clock frequency, then releases reset before it releases power-down. Last it sets the loop enable and then the output enable. After that it samples lock once per microsecond, for a bounded number of samples.

A gated variant is chosen per run at start. In this variant the block also turns off the output enable and stops the delay line's clock before the reset step. It computes a rounded 8-bit multiplier, the bus clock divided by a reference clock with a ×4 or ×8 factor, and waits a settling period before reset is released. It turns the clock back on once power-down is released.

Top module: `dll_lock_seq`

## Requirements
- R1: After reset, pwrsave_o is 1, dll_cfg_o and dll_cfg2_o are all zero, and done_o and timeout_o are 0.
- R2: Within a run, pwrsave_o goes to 0 before any bit of dll_cfg_o or dll_cfg2_o changes, and it stays 0 afterwards.
- R3: The run sets dll_cfg_o bit 30 (reset) before bit 29 (power-down). It clears bit 30 before bit 29. It then sets bit 16 (loop enable) and after that bit 18 (output enable). At completion bits 16 and 18 are 1 and bits 30 and 29 are 0.
- R4: dll_cfg_o[26:24] takes the band code of the bus frequency latched at start. The code is 0 for 112 MHz or less, 1 for 125 MHz or less, 2 for 137 MHz or less, 3 for 150 MHz or less, 4 for 162 MHz or less, 5 for 175 MHz or less, 6 for 187 MHz or less, and 7 for anything higher. Each bound is inclusive.
- R5: Every bus frequency above 200 MHz gives band code 7.
- R6: Lock is sampled in the first polling cycle (the first cycle with output enable set) and then every CLK_PER_US cycles, up to POLL_LIMIT samples in all. If every sample is low, timeout_o pulses in the cycle after the last sample.
- R7: done_o pulses in the cycle after the first sample that sees lock_i high, and never without lock_i high in the cycle before.
- R8: A start strobe that arrives while a run is in progress is ignored. The run completes exactly once, with the inputs latched at the accepted start.
- R9: In gated mode, output enable (dll_cfg_o bit 18) is 0 and clock-off (dll_cfg2_o bit 21) is 1 by the time reset rises. Clock-off falls only after power-down and reset are released. In normal mode dll_cfg2_o keeps its value.
- R10: In gated mode, dll_cfg2_o[17:10] becomes (bus_hz*8 + ref_hz/2)/ref_hz when fll_x8_i is 1, or (bus_hz*4 + ref_hz/2)/ref_hz when it is 0, with integer division.
- R11: The gated-mode multiplier saturates at 255 when the quotient is larger than 255 or when ref_hz is 0.
- R12: In gated mode, reset is released at least SETTLE_US*CLK_PER_US cycles after the multiplier is written.
- R13: done_o and timeout_o are one-cycle pulses, never high together, and a run produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| bus_hz_i | input | 32 | Bus clock frequency in Hz, latched at start |
| gate_mode_i | input | 1 | Selects the gated variant for this run, latched at start |
| ref_hz_i | input | 32 | Reference clock frequency in Hz, latched at start |
| fll_x8_i | input | 1 | Multiplier factor select (1: ×8, 0: ×4), latched at start |
| lock_i | input | 1 | Lock status from the delay line |
| pwrsave_o | output | 1 | Clock power-save enable |
| dll_cfg_o | output | 32 | Delay line configuration word |
| dll_cfg2_o | output | 32 | Second configuration word (clock-off, multiplier) |
| done_o | output | 1 | One-cycle pulse: lock seen |
| timeout_o | output | 1 | One-cycle pulse: lock never seen |

## Verification
The assertions assume that rst_n is held low through the first clock edge, that lock_i is a clean level in the clock domain, and that the bus and reference frequencies are stable only when start_i is accepted. The stimulus changes frequency and mode inputs only in the cycle of a start, or during a run to test that a second start is ignored. It holds lock_i low until the output enable has risen, then raises it after a chosen delay. Delays are drawn around the last polling sample, so both completion and timeout occur. Bus frequencies cluster near the band bounds and above 200 MHz. Reference frequencies include zero and small values that force saturation.

// File: rtl/dll_seq_pkg.sv
// Shared constants and types for the DLL reset and lock sequencer.
// Assumes: the delay line decodes the bit positions listed here.
package dll_seq_pkg;

    // Positions in the main configuration word
    localparam int unsigned CFG_RST_BIT   = 30;
    localparam int unsigned CFG_PDN_BIT   = 29;
    localparam int unsigned CFG_FREQ_LSB  = 24;
    localparam int unsigned CFG_OUTEN_BIT = 18;
    localparam int unsigned CFG_EN_BIT    = 16;

    // Positions in the second configuration word
    localparam int unsigned CFG2_CLKOFF_BIT = 21;
    localparam int unsigned CFG2_RATIO_LSB  = 10;

    localparam int unsigned FREQ_CODE_W = 3;
    localparam int unsigned RATIO_W     = 8;
    localparam int unsigned NUM_BANDS   = 7;

    typedef logic [31:0] band_t;

    // Inclusive upper bound of bands 0..6; anything higher is band 7
    localparam band_t BAND_CEIL [NUM_BANDS] = '{
        32'd112_000_000, 32'd125_000_000, 32'd137_000_000, 32'd150_000_000,
        32'd162_000_000, 32'd175_000_000, 32'd187_000_000
    };

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRSAVE,
        ST_GATE,
        ST_RST,
        ST_PDN,
        ST_FREQ,
        ST_RATIO,
        ST_SETTLE,
        ST_REL_RST,
        ST_REL_PDN,
        ST_UNGATE,
        ST_EN,
        ST_OUTEN,
        ST_POLL
    } seq_state_e;

endpackage

// File: rtl/dll_freq_ladder.sv
// Band code from the bus clock frequency.
// Each band bound is compared in parallel, and the code is the number of
// bounds exceeded. Since the bounds rise monotonically, the code saturates
// at 7 for every frequency above the top bound.
// Assumes: BAND_CEIL is strictly increasing.
module dll_freq_ladder
    import dll_seq_pkg::*;
#(
    parameter int unsigned HZ_W = 32
) (
    input  logic [HZ_W-1:0]        bus_hz_i,
    output logic [FREQ_CODE_W-1:0] code_o
);

    logic [NUM_BANDS-1:0] above;

    // One comparator per band bound
    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_cmp
        assign above[g] = (64'(bus_hz_i) > 64'(BAND_CEIL[g]));
    end

    // Count of exceeded bounds gives the band code
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_BANDS; i++) begin
            code_o = code_o + FREQ_CODE_W'(above[i]);
        end
    end

    // Lowest band and saturation at the top
    always_comb begin
        if (64'(bus_hz_i) <= 64'd112_000_000) begin
            AST_LOW_BAND: assert (code_o == '0); // R4
        end
        if (64'(bus_hz_i) > 64'd200_000_000) begin
            AST_TOP_SAT: assert (code_o == 3'd7); // R5
        end
    end

endmodule

// File: rtl/dll_us_timer.sv
// Microsecond pacing for the sequencer.
// While run_i is high, tick_o is high in the first cycle and then once
// every CYC_PER_US cycles. While run_i is low, the phase is held at zero.
// Assumes: CYC_PER_US >= 1.
module dll_us_timer #(
    parameter int unsigned CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_US - 1);

    logic [CNT_W-1:0] phase_q;

    // Step the phase counter while running, hold it at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && (phase_q == '0);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST); // R6

endmodule

// File: rtl/dll_ratio_div.sv
// Sequential restoring divider for the feedback multiplier.
// Produces one quotient bit per cycle and needs NUM_W cycles after start_i.
// The quotient saturates to all ones in Q_W bits. A zero divisor therefore
// saturates too.
// Assumes: start_i is not raised again while a division is in flight.
module dll_ratio_div #(
    parameter int unsigned NUM_W = 36,
    parameter int unsigned DEN_W = 32,
    parameter int unsigned Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             valid_o,
    output logic [Q_W-1:0]   quo_o
);

    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] num_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] left_q;
    logic             active_q;
    logic             valid_q;

    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial subtraction for the next quotient bit
    always_comb begin
        trial = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
        fits  = (trial >= {1'b0, den_q});
    end

    // Load operands on start, then shift one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            num_q    <= '0;
            quo_q    <= '0;
            den_q    <= '0;
            left_q   <= '0;
            active_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start_i) begin
                rem_q    <= '0;
                num_q    <= num_i;
                quo_q    <= '0;
                den_q    <= den_i;
                left_q   <= CNT_W'(NUM_W);
                active_q <= 1'b1;
            end else if (active_q) begin
                rem_q  <= fits ? (trial - {1'b0, den_q}) : trial;
                quo_q  <= {quo_q[NUM_W-2:0], fits};
                num_q  <= {num_q[NUM_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    valid_q  <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign quo_o   = (|quo_q[NUM_W-1:Q_W]) ? {Q_W{1'b1}} : quo_q[Q_W-1:0];

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && (den_q != '0) |-> (rem_q < {1'b0, den_q})); // R10

    AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R10

endmodule

// File: rtl/dll_lock_seq.sv
// DLL reset and lock sequencer (top).
// On start_i it latches the frequencies and the mode. It then steps
// through power-save off, an optional clock gating step, reset and
// power-down assertion, band code programming, an optional multiplier
// and settle phase, release of reset then power-down, optional clock
// ungating, loop enable, output enable, and paced lock polling.
// Assumes: lock_i is synchronous to clk; the delay line decodes the words.
module dll_lock_seq
    import dll_seq_pkg::*;
#(
    parameter int unsigned HZ_W       = 32,
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned POLL_LIMIT = 50,
    parameter int unsigned SETTLE_US  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [HZ_W-1:0] bus_hz_i,
    input  logic            gate_mode_i,
    input  logic [HZ_W-1:0] ref_hz_i,
    input  logic            fll_x8_i,
    input  logic            lock_i,
    output logic            pwrsave_o,
    output logic [31:0]     dll_cfg_o,
    output logic [31:0]     dll_cfg2_o,
    output logic            done_o,
    output logic            timeout_o
);

    localparam int unsigned NUM_W   = HZ_W + 4;
    localparam int unsigned CHK_MAX = (POLL_LIMIT > SETTLE_US) ? POLL_LIMIT : SETTLE_US;
    localparam int unsigned CHK_W   = $clog2(CHK_MAX + 1);
    localparam logic [CHK_W-1:0] POLL_LAST  = CHK_W'(POLL_LIMIT - 1);
    localparam logic [CHK_W-1:0] SETTLE_END = CHK_W'(SETTLE_US);

    seq_state_e state_q;

    logic [HZ_W-1:0]        bus_q;
    logic [HZ_W-1:0]        ref_q;
    logic                   gate_q;
    logic                   x8_q;
    logic                   pwrsave_q;
    logic                   rst_q;
    logic                   pdn_q;
    logic                   en_q;
    logic                   oe_q;
    logic                   clkoff_q;
    logic [FREQ_CODE_W-1:0] freq_q;
    logic [RATIO_W-1:0]     ratio_q;
    logic                   done_q;
    logic                   to_q;
    logic [CHK_W-1:0]       chk_q;

    logic [FREQ_CODE_W-1:0] band_code;
    logic                   timer_run;
    logic                   us_tick;
    logic                   div_go;
    logic                   div_valid;
    logic [RATIO_W-1:0]     div_quo;
    logic [NUM_W-1:0]       div_num;

    dll_freq_ladder #(
        .HZ_W (HZ_W)
    ) u_ladder (
        .bus_hz_i (bus_q),
        .code_o   (band_code)
    );

    // Pacing runs only while settling or polling
    assign timer_run = (state_q == ST_SETTLE) || (state_q == ST_POLL);

    dll_us_timer #(
        .CYC_PER_US (CLK_PER_US)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .tick_o (us_tick)
    );

    // Rounded numerator: bus times 8 or 4, plus half the reference
    always_comb begin
        div_num = (x8_q ? (NUM_W'(bus_q) << 3) : (NUM_W'(bus_q) << 2))
                  + NUM_W'(ref_q >> 1);
    end

    assign div_go = (state_q == ST_FREQ) && gate_q;

    dll_ratio_div #(
        .NUM_W (NUM_W),
        .DEN_W (HZ_W),
        .Q_W   (RATIO_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_go),
        .num_i   (div_num),
        .den_i   (ref_q),
        .valid_o (div_valid),
        .quo_o   (div_quo)
    );

    // Step the sequence one action per cycle and hold the control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bus_q     <= '0;
            ref_q     <= '0;
            gate_q    <= 1'b0;
            x8_q      <= 1'b0;
            pwrsave_q <= 1'b1;
            rst_q     <= 1'b0;
            pdn_q     <= 1'b0;
            en_q      <= 1'b0;
            oe_q      <= 1'b0;
            clkoff_q  <= 1'b0;
            freq_q    <= '0;
            ratio_q   <= '0;
            done_q    <= 1'b0;
            to_q      <= 1'b0;
            chk_q     <= '0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            if (!timer_run) begin
                chk_q <= '0;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        bus_q   <= bus_hz_i;
                        ref_q   <= ref_hz_i;
                        gate_q  <= gate_mode_i;
                        x8_q    <= fll_x8_i;
                        state_q <= ST_PWRSAVE;
                    end
                end
                ST_PWRSAVE: begin
                    pwrsave_q <= 1'b0;
                    state_q   <= gate_q ? ST_GATE : ST_RST;
                end
                ST_GATE: begin
                    oe_q     <= 1'b0;
                    clkoff_q <= 1'b1;
                    state_q  <= ST_RST;
                end
                ST_RST: begin
                    rst_q   <= 1'b1;
                    state_q <= ST_PDN;
                end
                ST_PDN: begin
                    pdn_q   <= 1'b1;
                    state_q <= ST_FREQ;
                end
                ST_FREQ: begin
                    freq_q  <= band_code;
                    state_q <= gate_q ? ST_RATIO : ST_REL_RST;
                end
                ST_RATIO: begin
                    if (div_valid) begin
                        ratio_q <= div_quo;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (us_tick) begin
                        if (chk_q == SETTLE_END) begin
                            state_q <= ST_REL_RST;
                        end else begin
                            chk_q <= chk_q + 1'b1;
                        end
                    end
                end
                ST_REL_RST: begin
                    rst_q   <= 1'b0;
                    state_q <= ST_REL_PDN;
                end
                ST_REL_PDN: begin
                    pdn_q   <= 1'b0;
                    state_q <= gate_q ? ST_UNGATE : ST_EN;
                end
                ST_UNGATE: begin
                    freq_q   <= band_code;
                    clkoff_q <= 1'b0;
                    state_q  <= ST_EN;
                end
                ST_EN: begin
                    en_q    <= 1'b1;
                    state_q <= ST_OUTEN;
                end
                ST_OUTEN: begin
                    oe_q    <= 1'b1;
                    state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (us_tick) begin
                        if (lock_i) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (chk_q == POLL_LAST) begin
                            to_q    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            chk_q <= chk_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Assemble the configuration words at their decoded positions
    always_comb begin
        dll_cfg_o = '0;
        dll_cfg_o[CFG_RST_BIT]   = rst_q;
        dll_cfg_o[CFG_PDN_BIT]   = pdn_q;
        dll_cfg_o[CFG_EN_BIT]    = en_q;
        dll_cfg_o[CFG_OUTEN_BIT] = oe_q;
        dll_cfg_o[CFG_FREQ_LSB +: FREQ_CODE_W] = freq_q;
        dll_cfg2_o = '0;
        dll_cfg2_o[CFG2_CLKOFF_BIT] = clkoff_q;
        dll_cfg2_o[CFG2_RATIO_LSB +: RATIO_W] = ratio_q;
    end

    assign pwrsave_o = pwrsave_q;
    assign done_o    = done_q;
    assign timeout_o = to_q;

    AST_PWRSAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dll_cfg_o) || !$stable(dll_cfg2_o)) |-> !pwrsave_o); // R2

    AST_PDN_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_cfg_o[CFG_PDN_BIT]) |-> dll_cfg_o[CFG_RST_BIT]); // R3

    AST_RST_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_cfg_o[CFG_PDN_BIT]) |-> !dll_cfg_o[CFG_RST_BIT]); // R3

    AST_EN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_cfg_o[CFG_EN_BIT]) |-> !dll_cfg_o[CFG_RST_BIT] && !dll_cfg_o[CFG_PDN_BIT]); // R3

    AST_OUT_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_cfg_o[CFG_OUTEN_BIT]) |-> dll_cfg_o[CFG_EN_BIT]); // R3

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> (chk_q <= POLL_LAST)); // R6

    AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(lock_i)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(bus_q) && $stable(gate_q)); // R8

    AST_GATE_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_cfg_o[CFG_RST_BIT]) && gate_q
        |-> dll_cfg2_o[CFG2_CLKOFF_BIT] && !dll_cfg_o[CFG_OUTEN_BIT]); // R9

    AST_UNGATE_AFTER_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_cfg2_o[CFG2_CLKOFF_BIT])
        |-> !dll_cfg_o[CFG_PDN_BIT] && !dll_cfg_o[CFG_RST_BIT]); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R13

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13

    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R13

endmodule

// File: tb/dll_lock_seq_bench.sv
// Self-checking bench for dll_lock_seq: directed corner cases plus seeded
// random runs, checked against expected values from bench functions.
module dll_lock_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int US         = 8;
    localparam int POLLS      = 50;
    localparam int SETTLE     = 5;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] bus_hz = '0;
    logic        gate_mode = 1'b0;
    logic [31:0] ref_hz = '0;
    logic        fll_x8 = 1'b0;
    logic        lock = 1'b0;
    logic        pwrsave_o;
    logic [31:0] dll_cfg_o;
    logic [31:0] dll_cfg2_o;
    logic        done_o;
    logic        timeout_o;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;

    dll_lock_seq #(
        .HZ_W       (32),
        .CLK_PER_US (US),
        .POLL_LIMIT (POLLS),
        .SETTLE_US  (SETTLE)
    ) u_dll_lock_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .bus_hz_i    (bus_hz),
        .gate_mode_i (gate_mode),
        .ref_hz_i    (ref_hz),
        .fll_x8_i    (fll_x8),
        .lock_i      (lock),
        .pwrsave_o   (pwrsave_o),
        .dll_cfg_o   (dll_cfg_o),
        .dll_cfg2_o  (dll_cfg2_o),
        .done_o      (done_o),
        .timeout_o   (timeout_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            errs = errs + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vecs = vecs + 1;
        if (!ok) begin
            errs = errs + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input longint hz);
        if (hz <= 112_000_000) return 0;
        if (hz <= 125_000_000) return 1;
        if (hz <= 137_000_000) return 2;
        if (hz <= 150_000_000) return 3;
        if (hz <= 162_000_000) return 4;
        if (hz <= 175_000_000) return 5;
        if (hz <= 187_000_000) return 6;
        return 7;
    endfunction

    function automatic longint exp_ratio(input longint bus, input longint rf, input bit x8);
        longint q;
        if (rf == 0) return 255;
        q = (bus * (x8 ? 8 : 4) + rf / 2) / rf;
        return (q > 255) ? 255 : q;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        lock  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwrsave_o == 1'b1, "R1 pwrsave", pwrsave_o, 1);
        check(dll_cfg_o == 32'd0 && dll_cfg2_o == 32'd0, "R1 words", dll_cfg_o | dll_cfg2_o, 0);
        check(done_o == 1'b0 && timeout_o == 1'b0, "R1 flags", {done_o, timeout_o}, 0);
    endtask

    // One run; lat < 0 holds lock high throughout
    task automatic run(input longint bus, input longint rf, input bit gm, input bit x8,
                       input int lat, input bit rst_first, input bit inject);
        int t_pws = -1, t_rst_on = -1, t_pdn_on = -1, t_rst_off = -1, t_pdn_off = -1;
        int t_en = -1, t_oe = -1, t_off_on = -1, t_off_off = -1, t_ratio = -1;
        int t_done = -1, t_to = -1, n_done = 0, n_to = 0, t_end = -1;
        int k;
        bit oe_at_rst = 1'b0;
        bit p_rst, p_pdn, p_en, p_oe, p_off;
        logic [7:0]  p_ratio;
        logic [31:0] cfg2_start;
        if (rst_first) do_reset();
        @(negedge clk);
        bus_hz    = 32'(bus);
        ref_hz    = 32'(rf);
        gate_mode = gm;
        fll_x8    = x8;
        start     = 1'b1;
        lock      = (lat < 0);
        p_rst = dll_cfg_o[30]; p_pdn = dll_cfg_o[29]; p_en = dll_cfg_o[16];
        p_oe = dll_cfg_o[18]; p_off = dll_cfg2_o[21]; p_ratio = dll_cfg2_o[17:10];
        cfg2_start = dll_cfg2_o;
        for (int t = 1; t < 5000; t++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && t == 6) begin
                start  = 1'b1;
                bus_hz = 32'd190_000_000;
                gate_mode = ~gm;
            end
            if (t_pws < 0 && !pwrsave_o) t_pws = t;
            if (dll_cfg_o[30] && !p_rst && t_rst_on < 0) begin t_rst_on = t; oe_at_rst = dll_cfg_o[18]; end
            if (!dll_cfg_o[30] && p_rst && t_rst_off < 0) t_rst_off = t;
            if (dll_cfg_o[29] && !p_pdn && t_pdn_on < 0) t_pdn_on = t;
            if (!dll_cfg_o[29] && p_pdn && t_pdn_off < 0) t_pdn_off = t;
            if (dll_cfg_o[16] && !p_en && t_en < 0) t_en = t;
            if (dll_cfg_o[18] && !p_oe && t_oe < 0) t_oe = t;
            if (dll_cfg2_o[21] && !p_off && t_off_on < 0) t_off_on = t;
            if (!dll_cfg2_o[21] && p_off && t_off_off < 0) t_off_off = t;
            if (dll_cfg2_o[17:10] != p_ratio && t_ratio < 0) t_ratio = t;
            p_rst = dll_cfg_o[30]; p_pdn = dll_cfg_o[29]; p_en = dll_cfg_o[16];
            p_oe = dll_cfg_o[18]; p_off = dll_cfg2_o[21]; p_ratio = dll_cfg2_o[17:10];
            if (done_o) begin n_done++; if (t_done < 0) t_done = t; end
            if (timeout_o) begin n_to++; if (t_to < 0) t_to = t; end
            if (t_end < 0 && (done_o || timeout_o)) t_end = t;
            if (lat >= 0) lock = (t_oe >= 0) && ((t - t_oe) >= lat);
            if (t_end >= 0 && t >= t_end + 40) break;
        end
        lock = 1'b0;
        // R13 and R8: exactly one completion pulse per accepted start
        check(n_done + n_to == 1, inject ? "R8 single completion" : "R13 single completion", n_done + n_to, 1);
        // R2: power-save drops before the first configuration change
        check(t_pws > 0 && (t_rst_on < 0 || t_pws < t_rst_on) && (t_off_on < 0 || t_pws < t_off_on),
              "R2 pwrsave first", t_pws, 1);
        check(!pwrsave_o, "R2 pwrsave stays off", pwrsave_o, 0);
        // R4/R5: band code from the originally latched frequency
        check(int'(dll_cfg_o[26:24]) == exp_code(bus), bus > 200_000_000 ? "R5 band code" : "R4 band code",
              dll_cfg_o[26:24], exp_code(bus));
        if (rst_first) begin
            check(t_rst_on < t_pdn_on && t_pdn_on < t_rst_off && t_rst_off < t_pdn_off
                  && t_pdn_off < t_en && t_en < t_oe && t_rst_on > 0,
                  "R3 step order", t_oe, t_en + 1);
            if (lat < 0) k = 0; else k = (lat + US - 1) / US;
            if (k < POLLS) begin
                check(t_done == t_oe + k * US + 1, "R7 done cycle", t_done, t_oe + k * US + 1);
            end else begin
                check(t_to == t_oe + (POLLS - 1) * US + 1, "R6 timeout cycle", t_to, t_oe + (POLLS - 1) * US + 1);
            end
        end else if (lat < 0) begin
            check(n_done == 1, "R7 done with lock held", n_done, 1);
        end
        if (n_done == 1) begin
            check(dll_cfg_o[16] && dll_cfg_o[18] && !dll_cfg_o[30] && !dll_cfg_o[29],
                  "R3 final bits", dll_cfg_o, 32'h0005_0000);
        end
        if (gm) begin
            if (rst_first) begin
                check(t_off_on > 0 && t_off_on < t_rst_on && !oe_at_rst, "R9 gate before reset", t_off_on, t_rst_on - 1);
                check(t_off_off > t_pdn_off, "R9 ungate after release", t_off_off, t_pdn_off + 1);
            end
            check(longint'(dll_cfg2_o[17:10]) == exp_ratio(bus, rf, x8),
                  exp_ratio(bus, rf, x8) == 255 ? "R11 ratio saturate" : "R10 ratio",
                  dll_cfg2_o[17:10], exp_ratio(bus, rf, x8));
            if (t_ratio > 0 && rst_first) begin
                check(t_rst_off - t_ratio >= SETTLE * US, "R12 settle", t_rst_off - t_ratio, SETTLE * US);
            end
        end else begin
            check(dll_cfg2_o == cfg2_start, "R9 cfg2 untouched", dll_cfg2_o, cfg2_start);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        do_reset();
        // Directed: band bounds and saturation
        run(112_000_000, 19_200_000, 0, 0, 0, 1, 0);
        run(112_000_001, 19_200_000, 0, 0, 3, 1, 0);
        run(187_000_000, 19_200_000, 0, 0, 9, 1, 0);
        run(200_000_000, 19_200_000, 0, 0, 0, 1, 0);
        run(250_000_000, 19_200_000, 0, 0, 0, 1, 0);
        run(64'd4_000_000_000, 19_200_000, 0, 0, 0, 1, 0);
        // Directed: last poll sample locks, one past it times out
        run(150_000_000, 19_200_000, 0, 0, (POLLS - 1) * US, 1, 0);
        run(150_000_000, 19_200_000, 0, 0, (POLLS - 1) * US + 1, 1, 0);
        // Directed: gated mode rounding and saturation
        run(100_000_000, 19_200_000, 1, 0, 0, 1, 0);
        run(100_000_000, 19_200_000, 1, 1, 5, 1, 0);
        run(200_000_000, 1_000_000, 1, 1, 0, 1, 0);
        run(150_000_000, 0, 1, 0, 0, 1, 0);
        // Directed: start during a run is ignored; back-to-back without reset
        run(100_000_000, 19_200_000, 0, 0, 20, 1, 1);
        run(100_000_000, 19_200_000, 1, 0, 20, 1, 1);
        run(170_000_000, 19_200_000, 0, 0, -1, 0, 0);
        run(130_000_000, 38_400_000, 1, 1, -1, 0, 0);
        // Seeded random runs
        for (int n = 0; n < 40; n++) begin
            longint b, r;
            int l;
            bit g, x;
            b = longint'($urandom_range(260_000_000, 50_000_000));
            case ($urandom_range(3, 0))
                0: r = 19_200_000;
                1: r = 38_400_000;
                2: r = longint'($urandom_range(40_000_000, 1_000_000));
                default: r = 24_000_000;
            endcase
            g = 1'($urandom_range(1, 0));
            x = 1'($urandom_range(1, 0));
            l = int'($urandom_range(POLLS * US + 20, 0));
            run(b, r, g, x, l, 1, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule